// File: doc/BRIEF.md
# Three-Wire Serial Shift Interface

This block is a register-mapped serial shift unit for three-wire synchronous transfers. It has a serial data output, a serial data input and a serial clock. It can act as either end of a link. An 8-bit shift register sends its most significant bit first and takes in arriving bits at the other end. Every clock transition, rising or falling, advances a 4-bit edge counter. Sixteen transitions make one byte. When the counter wraps, a completion flag is raised and the finished byte is copied into a read buffer. Software can therefore collect the byte while the next one moves.

The unit has no bit-rate generator of its own. The edges that drive it come from one of three sources, chosen by a clock-select field: a strobe bit written by software, a one-cycle timer pulse, or the serial clock pin seen through a synchronizer. When acting as master, software flips the level of the clock output by writing a toggle bit. The usual master loop writes strobe and toggle together sixteen times per byte. A slave instead counts the pin transitions of its partner.

Registers sit at four addresses of a small write-strobe bus. Reads are combinational. Address 0 is the shift register. Address 1 is the read buffer. Address 2 is status: completion flag in bit 7, edge count in bits 3:0. Address 3 is control: bit 7 toggle, bit 6 strobe, bits 5:4 wire mode, bits 3:1 clock select, bit 0 pin edge polarity.

Top module: `tws_shift_unit`

## Requirements
- R1: The unit moves data only while the wire-mode field (control bits 5:4) holds 01. With any other value, no edge is counted, nothing shifts, the toggle bit has no effect and the data output is held low. Strobe and toggle act under the wire mode and clock select already stored before that write.
- R2: A write to address 0 loads the shift register, and the data output shows its bit 7 from the next cycle. Each shift moves the register one place toward bit 7 and enters the held input bit at bit 0. After a byte, the register holds the input bits in arrival order, with the first at bit 7.
- R3: The edge counter goes up by one on every clock event. It wraps from 15 to 0, so one byte is sixteen events.
- R4: The event that wraps the counter sets the completion flag (status bit 7). Writing status with bit 7 set clears the flag. Writing it with bit 7 clear leaves the flag as it was.
- R5: The event that wraps the counter copies the shift register's new value into the read buffer (address 1). The buffer keeps that value until the next wrap.
- R6: Clock-select code 001 takes one event per control write with bit 6 set. Code 010 takes one event per cycle of the timer pulse. Code 100 uses the clock pin. Every other code takes no events. For strobe and timer events, an even count makes a sampling event and an odd count makes a shifting event.
- R7: With code 100, each transition of the clock pin is one event. The event reaches the counter on the third rising system-clock edge after the pin changes. When polarity bit 0 is 0, rising transitions sample and falling ones shift. When it is 1, the roles are swapped.
- R8: A control write with bit 7 set inverts the clock output level.
- R9: Status bits 3:0 read and load the edge count, and status bits 6:4 read as 0. Control reads return bits 5:0 as stored, with bits 7 and 6 reading as 0.
- R10: In a cycle that writes address 0 or address 2, that cycle's clock event is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| timer_pulse | input | 1 | One-cycle timer compare pulse |
| sck_in | input | 1 | Serial clock pin, input side |
| sck_out | output | 1 | Serial clock pin, driven level |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output |

## Verification
A strobe or timer event changes the counter, the flag, the buffer and the data output at the same rising edge that samples the write or the pulse. The bench therefore reads them back at the following falling edge. A pin transition goes through two synchronizer flops and an edge detector. Its count must not show after two rising edges but must show after the third, and the bench checks both sides of that boundary. Control read-back and the toggled clock output settle one edge after the write. Every expected value comes from a bench-side model that is stepped once per event.

// File: rtl/tws_pkg.sv
package tws_pkg;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_BUF  = 2'd1,
    REG_STAT = 2'd2,
    REG_CTRL = 2'd3
  } reg_sel_e;

  localparam logic [1:0] WM_3WIRE = 2'b01;

  localparam logic [2:0] CS_SOFT  = 3'b001;
  localparam logic [2:0] CS_TIMER = 3'b010;
  localparam logic [2:0] CS_PIN   = 3'b100;

  localparam int CTRL_POL   = 0;
  localparam int CTRL_CS_LO = 1;
  localparam int CTRL_WM_LO = 4;
  localparam int CTRL_STB   = 6;
  localparam int CTRL_TGL   = 7;
  localparam int STAT_FLAG  = 7;

endpackage

// File: rtl/tws_clk_src.sv
module tws_clk_src
  import tws_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic [2:0] csel,
  input  logic       edge_pol,
  input  logic       strobe,
  input  logic       timer_pulse,
  input  logic       pin,
  input  logic       count_odd,
  input  logic       hold,
  output logic       ev_valid,
  output logic       ev_sample
);

  logic [SYNC_STAGES:0] pin_q;
  logic [SYNC_STAGES:0] pin_d;
  logic                 pin_now;
  logic                 pin_prev;
  logic                 pin_rise;
  logic                 pin_fall;
  logic                 raw_ev;
  logic                 raw_kind;

  assign pin_d = {pin_q[SYNC_STAGES-1:0], pin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= pin_d;
  end

  assign pin_now  = pin_q[SYNC_STAGES-1];
  assign pin_prev = pin_q[SYNC_STAGES];
  assign pin_rise = pin_now & ~pin_prev;
  assign pin_fall = ~pin_now & pin_prev;

  always_comb begin
    raw_ev   = 1'b0;
    raw_kind = 1'b0;
    case (csel)
      CS_SOFT: begin
        raw_ev   = strobe;
        raw_kind = ~count_odd;
      end
      CS_TIMER: begin
        raw_ev   = timer_pulse;
        raw_kind = ~count_odd;
      end
      CS_PIN: begin
        raw_ev   = pin_rise | pin_fall;
        raw_kind = edge_pol ? pin_fall : pin_rise;
      end
      default: begin
        raw_ev   = 1'b0;
        raw_kind = 1'b0;
      end
    endcase
  end

  assign ev_valid  = raw_ev & enable & ~hold;
  assign ev_sample = raw_kind;

endmodule

// File: rtl/tws_edge_counter.sv
module tws_edge_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             flag,
  output logic             wrap
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             flag_q;
  logic             flag_d;
  logic             flag_en;

  assign wrap = ev & (cnt_q == {CNT_W{1'b1}});

  always_comb begin
    cnt_en = ld_en | ev;
    cnt_d  = cnt_q;
    if (ld_en)   cnt_d = ld_val;
    else if (ev) cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    flag_en = wrap | flag_clr;
    flag_d  = flag_q;
    if (wrap)          flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (cnt_en)  cnt_q  <= cnt_d;
      if (flag_en) flag_q <= flag_d;
    end
  end

  assign cnt  = cnt_q;
  assign flag = flag_q;

endmodule

// File: rtl/tws_shifter.sv
module tws_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev,
  input  logic              ev_sample,
  input  logic              wrap,
  input  logic              ld_en,
  input  logic [DATA_W-1:0] ld_val,
  input  logic              sdi,
  output logic [DATA_W-1:0] dr,
  output logic [DATA_W-1:0] rbuf
);

  logic [DATA_W-1:0] dr_q;
  logic [DATA_W-1:0] dr_d;
  logic              dr_en;
  logic              samp_q;
  logic              samp_en;
  logic [DATA_W-1:0] buf_q;
  logic              shift_ev;

  assign shift_ev = ev & ~ev_sample;
  assign samp_en  = ev & ev_sample;

  always_comb begin
    dr_en = ld_en | shift_ev;
    dr_d  = dr_q;
    if (ld_en)         dr_d = ld_val;
    else if (shift_ev) dr_d = {dr_q[DATA_W-2:0], samp_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_q   <= '0;
      samp_q <= 1'b0;
      buf_q  <= '0;
    end else begin
      if (dr_en)   dr_q   <= dr_d;
      if (samp_en) samp_q <= sdi;
      if (wrap)    buf_q  <= dr_d;
    end
  end

  assign dr   = dr_q;
  assign rbuf = buf_q;

endmodule

// File: rtl/tws_shift_unit.sv
module tws_shift_unit
  import tws_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              timer_pulse,
  input  logic              sck_in,
  output logic              sck_out,
  input  logic              sdi,
  output logic              sdo
);

  localparam int CNT_W = $clog2(2 * DATA_W);

  logic [1:0]        rst_sync_q;
  logic              rst_core_n;

  logic [1:0]        wm_q;
  logic [2:0]        cs_q;
  logic              pol_q;
  logic              sck_q;
  logic              sck_d;
  logic              sck_en;

  logic              wr_data;
  logic              wr_stat;
  logic              wr_ctrl;
  logic              wr_stb;
  logic              wr_tgl;
  logic              three_wire;
  logic              blk;
  logic              stat_clr;

  logic              ev;
  logic              ev_sample;
  logic              wrap;
  logic [CNT_W-1:0]  cnt;
  logic              flag;
  logic [DATA_W-1:0] dr;
  logic [DATA_W-1:0] rbuf;
  logic [DATA_W-1:0] stat_v;
  logic [DATA_W-1:0] ctrl_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign wr_data    = reg_we & (reg_addr == REG_DATA);
  assign wr_stat    = reg_we & (reg_addr == REG_STAT);
  assign wr_ctrl    = reg_we & (reg_addr == REG_CTRL);
  assign wr_stb     = wr_ctrl & reg_wdata[CTRL_STB];
  assign wr_tgl     = wr_ctrl & reg_wdata[CTRL_TGL];
  assign three_wire = (wm_q == WM_3WIRE);
  assign blk        = wr_data | wr_stat;
  assign stat_clr   = wr_stat & reg_wdata[STAT_FLAG];

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      wm_q  <= '0;
      cs_q  <= '0;
      pol_q <= 1'b0;
    end else if (wr_ctrl) begin
      wm_q  <= reg_wdata[CTRL_WM_LO +: 2];
      cs_q  <= reg_wdata[CTRL_CS_LO +: 3];
      pol_q <= reg_wdata[CTRL_POL];
    end
  end

  always_comb begin
    sck_en = wr_tgl & three_wire;
    sck_d  = ~sck_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  sck_q <= 1'b0;
    else if (sck_en)  sck_q <= sck_d;
  end

  tws_clk_src #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_clk_src (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .enable      (three_wire),
    .csel        (cs_q),
    .edge_pol    (pol_q),
    .strobe      (wr_stb),
    .timer_pulse (timer_pulse),
    .pin         (sck_in),
    .count_odd   (cnt[0]),
    .hold        (blk),
    .ev_valid    (ev),
    .ev_sample   (ev_sample)
  );

  tws_edge_counter #(
    .CNT_W (CNT_W)
  ) u_counter (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .ev       (ev),
    .ld_en    (wr_stat),
    .ld_val   (reg_wdata[CNT_W-1:0]),
    .flag_clr (stat_clr),
    .cnt      (cnt),
    .flag     (flag),
    .wrap     (wrap)
  );

  tws_shifter #(
    .DATA_W (DATA_W)
  ) u_shifter (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .ev        (ev),
    .ev_sample (ev_sample),
    .wrap      (wrap),
    .ld_en     (wr_data),
    .ld_val    (reg_wdata),
    .sdi       (sdi),
    .dr        (dr),
    .rbuf      (rbuf)
  );

  always_comb begin
    stat_v              = '0;
    stat_v[STAT_FLAG]   = flag;
    stat_v[CNT_W-1:0]   = cnt;
    ctrl_v              = '0;
    ctrl_v[CTRL_POL]    = pol_q;
    ctrl_v[CTRL_CS_LO +: 3] = cs_q;
    ctrl_v[CTRL_WM_LO +: 2] = wm_q;
  end

  always_comb begin
    case (reg_sel_e'(reg_addr))
      REG_DATA: reg_rdata = dr;
      REG_BUF:  reg_rdata = rbuf;
      REG_STAT: reg_rdata = stat_v;
      REG_CTRL: reg_rdata = ctrl_v;
      default:  reg_rdata = '0;
    endcase
  end

  assign sdo     = three_wire & dr[DATA_W-1];
  assign sck_out = sck_q;

endmodule

// File: rtl/tws_shift_unit_chk.sv
module tws_shift_unit_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              ev,
  input logic              ev_sample,
  input logic              three_wire,
  input logic              wr_data,
  input logic              wr_stat,
  input logic              wr_tgl,
  input logic              stat_clr,
  input logic [CNT_W-1:0]  cnt,
  input logic              flag,
  input logic [DATA_W-1:0] dr,
  input logic [DATA_W-1:0] rbuf,
  input logic              sdo,
  input logic              sck_out
);

  // R3: one step per event, wrapping
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_core_n)
    ev |=> cnt == CNT_W'($past(cnt) + 1'b1));

  // R4: wrap raises the flag
  a_r4_flag_on_wrap: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ev && cnt == {CNT_W{1'b1}}) |=> flag);

  // R4: write-one clears when no wrap coincides
  a_r4_flag_clear: assert property (@(posedge clk) disable iff (!rst_core_n)
    stat_clr |=> !flag);

  // R5: buffer matches the shift register right after a wrap
  a_r5_buffer_copy: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ev && cnt == {CNT_W{1'b1}}) |=> rbuf == dr);

  // R2: a shifting event moves bit 6 onto the data output
  a_r2_msb_out: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ev && !ev_sample && three_wire) |=> sdo == $past(dr[DATA_W-2]));

  // R1: outside three-wire mode the count holds
  a_r1_idle_mode: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!three_wire && !wr_stat) |=> $stable(cnt));

  // R8: toggle inverts the clock output
  a_r8_toggle: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_tgl && three_wire) |=> sck_out != $past(sck_out));

  // R10: a data write drops the concurrent event
  a_r10_write_blocks: assert property (@(posedge clk) disable iff (!rst_core_n)
    wr_data |=> $stable(cnt));

endmodule

bind tws_shift_unit tws_shift_unit_chk #(
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .ev         (ev),
  .ev_sample  (ev_sample),
  .three_wire (three_wire),
  .wr_data    (wr_data),
  .wr_stat    (wr_stat),
  .wr_tgl     (wr_tgl),
  .stat_clr   (stat_clr),
  .cnt        (cnt),
  .flag       (flag),
  .dr         (dr),
  .rbuf       (rbuf),
  .sdo        (sdo),
  .sck_out    (sck_out)
);

// File: tb/test_tws_shift_unit.sv
`timescale 1ns/1ps
module test_tws_shift_unit;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_we;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       timer_pulse;
  logic       sck_in;
  logic       sck_out;
  logic       sdi;
  logic       sdo;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 1'b0;

  logic [7:0] exp_dr;
  logic [7:0] exp_buf;
  int         exp_cnt;
  logic       exp_flag;
  logic       exp_samp;
  logic       exp_sck;

  always #2.5 clk = ~clk;

  tws_shift_unit i_tws_shift_unit (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .timer_pulse (timer_pulse),
    .sck_in      (sck_in),
    .sck_out     (sck_out),
    .sdi         (sdi),
    .sdo         (sdo)
  );

  function automatic void model_event(input bit is_sample, input bit din);
    if (is_sample) exp_samp = din;
    else           exp_dr   = {exp_dr[6:0], exp_samp};
    if (exp_cnt == 15) begin
      exp_cnt  = 0;
      exp_flag = 1'b1;
      exp_buf  = exp_dr;
    end else begin
      exp_cnt = exp_cnt + 1;
    end
  endfunction

  function automatic logic [7:0] exp_stat();
    return {exp_flag, 3'b000, 4'(exp_cnt)};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [1:0] a, input logic [7:0] exp);
    reg_addr = a;
    #0.5;
    check(req, reg_rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] rx;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
    timer_pulse = 1'b0; sck_in = 1'b0; sdi = 1'b0;
    exp_dr = 8'h00; exp_buf = 8'h00; exp_cnt = 0; exp_flag = 1'b0;
    exp_samp = 1'b0; exp_sck = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    rd_check("R9 reset status", 2'd2, 8'h00);
    rd_check("R9 reset ctrl", 2'd3, 8'h00);
    rd_check("R5 reset buffer", 2'd1, 8'h00);
    check("R8 reset sck", {7'd0, sck_out}, 8'h00);

    // software strobe master transfers, random bytes
    wr(2'd3, 8'h12);
    rd_check("R9 ctrl readback", 2'd3, 8'h12);
    for (int byte_i = 0; byte_i < 6; byte_i++) begin
      logic [7:0] tx;
      tx = 8'($urandom);
      if (byte_i == 0) tx = 8'hFF;
      if (byte_i == 1) tx = 8'h00;
      wr(2'd0, tx);
      exp_dr = tx;
      check("R2 first bit on sdo", {7'd0, sdo}, {7'd0, tx[7]});
      rx = 8'h00;
      for (int e = 0; e < 16; e++) begin
        bit b;
        b = 1'($urandom);
        sdi = b;
        if ((exp_cnt % 2) == 0) rx = {rx[6:0], b};
        wr(2'd3, 8'hD2);
        model_event((exp_cnt % 2) == 0, b);
        exp_sck = ~exp_sck;
        check("R2 sdo tracks bit 7", {7'd0, sdo}, {7'd0, exp_dr[7]});
        check("R8 sck toggled", {7'd0, sck_out}, {7'd0, exp_sck});
        if (e == 7) rd_check("R3 mid-byte count", 2'd2, exp_stat());
      end
      rd_check("R2 received byte", 2'd0, rx);
      rd_check("R5 buffer holds byte", 2'd1, rx);
      rd_check("R4 flag set at wrap", 2'd2, 8'h80);
      rd_check("R9 strobe/toggle read 0", 2'd3, 8'h12);
      wr(2'd2, 8'h80);
      exp_flag = 1'b0;
      rd_check("R4 flag cleared", 2'd2, 8'h00);
    end

    // R4 writing 0 keeps the flag; R9 preload
    wr(2'd2, 8'h0E);
    exp_cnt = 14;
    rd_check("R9 preload readback", 2'd2, exp_stat());
    sdi = 1'b1;
    wr(2'd3, 8'h52); model_event(1'b1, 1'b1);
    wr(2'd3, 8'h52); model_event(1'b0, 1'b1);
    rd_check("R4 wrap after preload", 2'd2, 8'h80);
    rd_check("R5 buffer after preload", 2'd1, exp_buf);
    wr(2'd2, 8'h73);
    exp_cnt = 3;
    rd_check("R4 write 0 keeps flag R9 high bits 0", 2'd2, 8'h83);
    wr(2'd2, 8'h80);
    exp_cnt = 0; exp_flag = 1'b0;

    // R5 buffer untouched by shifting before next wrap
    wr(2'd3, 8'h52); model_event(1'b1, 1'b1);
    wr(2'd3, 8'h52); model_event(1'b0, 1'b1);
    rd_check("R5 buffer stable mid-byte", 2'd1, exp_buf);

    // R1 mode off: strobe and toggle ignored, sdo low
    wr(2'd3, 8'h02);
    wr(2'd3, 8'hC2);
    rd_check("R1 no count when mode off", 2'd2, exp_stat());
    rd_check("R1 no shift when mode off", 2'd0, exp_dr);
    check("R1 sck unchanged", {7'd0, sck_out}, {7'd0, exp_sck});
    wr(2'd0, 8'hFF); exp_dr = 8'hFF;
    check("R1 sdo held low", {7'd0, sdo}, 8'h00);

    // R6 unused clock-select code
    wr(2'd3, 8'h10);
    wr(2'd3, 8'h50);
    rd_check("R6 idle select takes no strobe", 2'd2, exp_stat());

    // R6 timer source
    wr(2'd3, 8'h14);
    wr(2'd2, 8'h00); exp_cnt = 0;
    for (int p = 0; p < 24; p++) begin
      bit b;
      b = 1'($urandom);
      @(negedge clk);
      sdi = b; timer_pulse = 1'b1;
      @(negedge clk);
      timer_pulse = 1'b0;
      model_event((exp_cnt % 2) == 0, b);
    end
    rd_check("R6 timer count", 2'd2, exp_stat());
    rd_check("R6 timer data", 2'd0, exp_dr);
    rd_check("R6 timer buffer", 2'd1, exp_buf);

    // R10 data write with concurrent timer pulse
    @(negedge clk);
    timer_pulse = 1'b1; reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 8'hA5;
    @(negedge clk);
    timer_pulse = 1'b0; reg_we = 1'b0;
    exp_dr = 8'hA5;
    rd_check("R10 event dropped", 2'd2, exp_stat());
    rd_check("R10 data written", 2'd0, 8'hA5);

    // R7 external pin, both polarities
    wr(2'd2, 8'h80); exp_cnt = 0; exp_flag = 1'b0;
    for (int pol = 0; pol < 2; pol++) begin
      wr(2'd3, 8'h18 | 8'(pol));
      for (int t = 0; t < 16; t++) begin
        bit b;
        bit rising;
        b = 1'($urandom);
        @(negedge clk);
        sdi = b;
        sck_in = ~sck_in;
        rising = sck_in;
        repeat (2) @(posedge clk);
        @(negedge clk);
        if (t == 0) rd_check("R7 not before third edge", 2'd2, exp_stat());
        @(posedge clk);
        @(negedge clk);
        model_event(pol == 0 ? rising : !rising, b);
        if (t == 0 || t == 15) rd_check("R7 count after third edge", 2'd2, exp_stat());
      end
      rd_check("R7 pin data", 2'd0, exp_dr);
      rd_check("R7 pin buffer", 2'd1, exp_buf);
      wr(2'd2, 8'h80); exp_flag = 1'b0; exp_cnt = 0;
    end

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule